// File: doc/BRIEF.md
# Scratchpad Fill Chain DMA Controller

This block drives one DMA channel that copies quadwords from main memory into a local scratchpad. In normal mode it moves a programmed number of quadwords from a programmed data address and then finishes. In chain mode it walks a linked list of 128-bit descriptors ("tags") held in main memory. Each tag gives a quadword count and the address of that packet's data, and it also says whether the walk goes on after the packet.

Software loads the starting data address, count, tag address and scratchpad address on the same cycle as a start pulse. It also sets three options at that time: chain mode, tag forwarding (the tag quadword itself is copied into the scratchpad ahead of its data) and stop-on-interrupt. The block then issues single-outstanding reads on the memory port and writes each returned quadword to consecutive scratchpad slots. At the end it raises a one-cycle done pulse and drops its busy flag.

Top module: `spad_chain_dma`

## Requirements
- R1: After reset, `busy`, `done_irq`, `spad_we` and `mem_rd_req` are all low.
- R2: In normal mode (`cfg_chain`=0) the block reads `init_count` quadwords from `init_data_addr`, stepping by 16 bytes. It writes them in order to scratchpad slots starting at `init_spad_addr` and stepping by one slot, fetches no tag, and then finishes.
- R3: In chain mode, a nonzero `init_count` is moved first from `init_data_addr` with no tag fetch. The first tag is read from `init_tag_addr` only after that.
- R4: Tag layout: bits [15:0] hold the quadword count, bits [30:28] the tag ID, bit 31 the interrupt flag and bits [63:32] the data address. After a tag, the packet's data is read from that address.
- R5: A tag whose ID is neither 0 nor 7 continues the walk. The next tag is read at the current tag address + 16 + 16 × count. This also holds for a count of zero.
- R6: A tag with ID 7 (end) or ID 0 (end, data by reference) finishes the walk after its data, and no further tag is read.
- R7: A tag with the interrupt flag set finishes the walk after its data only when `cfg_irq_en` was set at start. With `cfg_irq_en` clear, the walk goes on.
- R8: With `cfg_tag_fwd` set, each fetched tag quadword is written unchanged into the next scratchpad slot before that packet's data.
- R9: Completion produces exactly one single-cycle `done_irq` pulse per start, and `busy` is low in the cycle after it.
- R10: A finishing tag with a count of zero ends the walk with no data read. Only the tag itself is written, and only when forwarding is on.
- R11: At most one memory read is outstanding, and `mem_rd_req` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chain | input | 1 | 1 = chain mode, 0 = normal mode; sampled at start |
| cfg_tag_fwd | input | 1 | Copy each tag into the scratchpad; sampled at start |
| cfg_irq_en | input | 1 | Let the tag interrupt flag end the walk; sampled at start |
| start_set | input | 1 | Start pulse, ignored while busy |
| init_data_addr | input | ADDR_W | Initial data byte address |
| init_count | input | CNT_W | Initial pending quadword count |
| init_tag_addr | input | ADDR_W | First tag byte address |
| init_spad_addr | input | SPAD_AW | First scratchpad slot |
| busy | output | 1 | Channel active |
| done_irq | output | 1 | One-cycle completion pulse |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Quadword-aligned read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | QW_W | Read data |
| spad_we | output | 1 | Scratchpad write enable |
| spad_addr | output | SPAD_AW | Scratchpad slot |
| spad_wdata | output | QW_W | Scratchpad write data |

## Verification
Normal mode is swept over counts 1 to 5 at shifted addresses. This shows that the length and both address steps are right and that no tag is ever fetched. Chain runs cover the following cases, each told apart by the logged read-address sequence:
- a continue tag followed by an end tag, which tests the tag-address arithmetic;
- a by-reference end tag with a live tag planted right after it, to catch overrun;
- an interrupt-flagged tag with the enable on and off;
- a pending count ahead of the first tag;
- zero-count continue and end tags.

Repeating the two-tag chain with forwarding on checks where the tag quadwords land among the data in the scratchpad.

// File: rtl/scdma_pkg.sv
package scdma_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_TAG_RD,
      S_TAG_WAIT,
      S_DAT_RD,
      S_DAT_WAIT,
      S_DONE
   } scdma_state_t;

   localparam int TAG_ID_W   = 3;
   localparam int TAG_CNT_LO = 0;
   localparam int TAG_ID_LO  = 28;
   localparam int TAG_IRQ_B  = 31;
   localparam int TAG_ADR_LO = 32;

   localparam logic [TAG_ID_W-1:0] ID_REF_END = 3'd0;
   localparam logic [TAG_ID_W-1:0] ID_END     = 3'd7;
endpackage

// File: rtl/scdma_tag_decode.sv
module scdma_tag_decode #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic [CNT_W-1:0]               tag_cnt,
   input  logic [scdma_pkg::TAG_ID_W-1:0] tag_id,
   input  logic                           tag_irq,
   input  logic [ADDR_W-1:0]              tag_addr,
   input  logic                           irq_en,
   output logic [CNT_W-1:0]               pkt_cnt,
   output logic [ADDR_W-1:0]              pkt_addr,
   output logic                           pkt_stop
);
   import scdma_pkg::*;

   if (CNT_W > 16) begin : g_cnt_bad
      $error("CNT_W must fit the 16-bit tag count field");
   end
   if (ADDR_W > 32) begin : g_addr_bad
      $error("ADDR_W must fit the 32-bit tag address word");
   end

   logic id_ends;

   always_comb begin
      id_ends  = (tag_id == ID_END) || (tag_id == ID_REF_END);
      pkt_stop = id_ends || (tag_irq && irq_en);
      pkt_cnt  = tag_cnt;
      pkt_addr = tag_addr;
   end
endmodule

// File: rtl/scdma_rd_port.sv
module scdma_rd_port #(
   parameter int ADDR_W = 32,
   parameter int QB_LOG = 4,
   parameter bit ALIGN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_addr,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr
);
   logic [ADDR_W-1:0] addr_fmt;

   if (ALIGN) begin : g_align
      assign addr_fmt = {issue_addr[ADDR_W-1:QB_LOG], {QB_LOG{1'b0}}};
   end else begin : g_raw
      assign addr_fmt = issue_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd_req  <= 1'b0;
         mem_rd_addr <= '0;
      end else begin
         mem_rd_req <= issue;
         if (issue) mem_rd_addr <= addr_fmt;
      end
   end
endmodule

// File: rtl/scdma_spad_wr.sv
module scdma_spad_wr #(
   parameter int QW_W    = 128,
   parameter int SPAD_AW = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [SPAD_AW-1:0] load_addr,
   input  logic               wr,
   input  logic [QW_W-1:0]    wr_data,
   output logic               spad_we,
   output logic [SPAD_AW-1:0] spad_addr,
   output logic [QW_W-1:0]    spad_wdata
);
   logic [SPAD_AW-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_addr;
      else if (wr)   ptr <= ptr + SPAD_AW'(1);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            spad_we    <= 1'b0;
            spad_addr  <= '0;
            spad_wdata <= '0;
         end else begin
            spad_we <= wr;
            if (wr) begin
               spad_addr  <= ptr;
               spad_wdata <= wr_data;
            end
         end
      end
   end else begin : g_comb
      assign spad_we    = wr;
      assign spad_addr  = ptr;
      assign spad_wdata = wr_data;
   end
endmodule

// File: rtl/spad_chain_dma.sv
module spad_chain_dma #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int SPAD_AW = 8,
   parameter int QW_W    = 128,
   parameter bit WR_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_chain,
   input  logic               cfg_tag_fwd,
   input  logic               cfg_irq_en,
   input  logic               start_set,
   input  logic [ADDR_W-1:0]  init_data_addr,
   input  logic [CNT_W-1:0]   init_count,
   input  logic [ADDR_W-1:0]  init_tag_addr,
   input  logic [SPAD_AW-1:0] init_spad_addr,
   output logic               busy,
   output logic               done_irq,
   output logic               mem_rd_req,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [QW_W-1:0]    mem_rd_data,
   output logic               spad_we,
   output logic [SPAD_AW-1:0] spad_addr,
   output logic [QW_W-1:0]    spad_wdata
);
   import scdma_pkg::*;

   localparam int QW_BYTES = QW_W / 8;
   localparam int QB_LOG   = $clog2(QW_BYTES);
   localparam logic [ADDR_W-1:0] QW_STEP = ADDR_W'(QW_BYTES);

   if (QW_W < 64 || (QW_W % 8) != 0) begin : g_qw_bad
      $error("QW_W must be a byte multiple of at least 64 bits");
   end
   if (CNT_W > ADDR_W) begin : g_cw_bad
      $error("CNT_W must not exceed ADDR_W");
   end

   scdma_state_t      state;
   logic              fwd_q, ien_q, fin_q;
   logic [ADDR_W-1:0] data_addr, tag_addr;
   logic [CNT_W-1:0]  cnt_q;

   logic [CNT_W-1:0]  dec_cnt;
   logic [ADDR_W-1:0] dec_addr;
   logic              dec_stop;
   logic              issue, wr, load;
   logic [ADDR_W-1:0] issue_addr;
   logic [ADDR_W-1:0] next_tag;

   scdma_tag_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dec_i (
      .tag_cnt  (mem_rd_data[TAG_CNT_LO +: CNT_W]),
      .tag_id   (mem_rd_data[TAG_ID_LO +: TAG_ID_W]),
      .tag_irq  (mem_rd_data[TAG_IRQ_B]),
      .tag_addr (mem_rd_data[TAG_ADR_LO +: ADDR_W]),
      .irq_en   (ien_q),
      .pkt_cnt  (dec_cnt),
      .pkt_addr (dec_addr),
      .pkt_stop (dec_stop)
   );

   always_comb begin
      issue      = (state == S_TAG_RD) || (state == S_DAT_RD);
      issue_addr = (state == S_TAG_RD) ? tag_addr : data_addr;
      wr         = mem_rd_valid &&
                   ((state == S_DAT_WAIT) || ((state == S_TAG_WAIT) && fwd_q));
      load       = (state == S_IDLE) && start_set;
      next_tag   = tag_addr + QW_STEP + (ADDR_W'(dec_cnt) << QB_LOG);
      done_irq   = (state == S_DONE);
   end

   scdma_rd_port #(.ADDR_W(ADDR_W), .QB_LOG(QB_LOG), .ALIGN(1'b1)) rd_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (issue),
      .issue_addr  (issue_addr),
      .mem_rd_req  (mem_rd_req),
      .mem_rd_addr (mem_rd_addr)
   );

   scdma_spad_wr #(.QW_W(QW_W), .SPAD_AW(SPAD_AW), .REG_OUT(WR_REG)) wr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (init_spad_addr),
      .wr         (wr),
      .wr_data    (mem_rd_data),
      .spad_we    (spad_we),
      .spad_addr  (spad_addr),
      .spad_wdata (spad_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         busy      <= 1'b0;
         fwd_q     <= 1'b0;
         ien_q     <= 1'b0;
         fin_q     <= 1'b0;
         data_addr <= '0;
         tag_addr  <= '0;
         cnt_q     <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start_set) begin
                  busy      <= 1'b1;
                  fwd_q     <= cfg_tag_fwd;
                  ien_q     <= cfg_irq_en;
                  fin_q     <= !cfg_chain;
                  data_addr <= init_data_addr;
                  tag_addr  <= init_tag_addr;
                  cnt_q     <= init_count;
                  if (init_count != '0) state <= S_DAT_RD;
                  else if (cfg_chain)   state <= S_TAG_RD;
                  else                  state <= S_DONE;
               end
            end
            S_TAG_RD: state <= S_TAG_WAIT;
            S_TAG_WAIT: begin
               if (mem_rd_valid) begin
                  data_addr <= dec_addr;
                  cnt_q     <= dec_cnt;
                  fin_q     <= dec_stop;
                  tag_addr  <= next_tag;
                  if (dec_cnt != '0) state <= S_DAT_RD;
                  else if (dec_stop) state <= S_DONE;
                  else               state <= S_TAG_RD;
               end
            end
            S_DAT_RD: state <= S_DAT_WAIT;
            S_DAT_WAIT: begin
               if (mem_rd_valid) begin
                  data_addr <= data_addr + QW_STEP;
                  cnt_q     <= cnt_q - CNT_W'(1);
                  if (cnt_q == CNT_W'(1)) state <= fin_q ? S_DONE : S_TAG_RD;
                  else                    state <= S_DAT_RD;
               end
            end
            S_DONE: begin
               busy  <= 1'b0;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/scdma_chk.sv
module scdma_chk #(
   parameter int SPAD_AW = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done_irq,
   input logic               mem_rd_req,
   input logic               mem_rd_valid,
   input logic               spad_we,
   input logic [SPAD_AW-1:0] spad_addr
);
   logic               outst;
   logic               have_wr;
   logic [SPAD_AW-1:0] last_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            outst <= 1'b0;
      else if (mem_rd_req)   outst <= 1'b1;
      else if (mem_rd_valid) outst <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_wr <= 1'b0;
         last_wr <= '0;
      end else if (!busy) begin
         have_wr <= 1'b0;
      end else if (spad_we) begin
         // R2
         if (have_wr) begin
            spad_step_chk: assert (spad_addr == last_wr + SPAD_AW'(1))
               else $error("scratchpad slot did not step by one");
         end
         have_wr <= 1'b1;
         last_wr <= spad_addr;
      end
   end

   // R11
   one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !outst);

   // R11
   read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> busy);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> (!done_irq && !busy));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spad_we);
endmodule

bind spad_chain_dma scdma_chk #(.SPAD_AW(SPAD_AW)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done_irq     (done_irq),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_valid (mem_rd_valid),
   .spad_we      (spad_we),
   .spad_addr    (spad_addr)
);

// File: tb/spad_chain_dma_tb_top.sv
`timescale 1ns/1ps
module spad_chain_dma_tb_top;
   localparam int AW = 32, CW = 16, SAW = 8, QW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            cfg_chain = 0, cfg_tag_fwd = 0, cfg_irq_en = 0, start_set = 0;
   logic [AW-1:0]   init_data_addr = '0, init_tag_addr = '0;
   logic [CW-1:0]   init_count = '0;
   logic [SAW-1:0]  init_spad_addr = '0;
   logic            busy, done_irq, mem_rd_req, spad_we;
   logic [AW-1:0]   mem_rd_addr;
   logic            mem_rd_valid;
   logic [QW-1:0]   mem_rd_data;
   logic [SAW-1:0]  spad_addr;
   logic [QW-1:0]   spad_wdata;

   spad_chain_dma dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_chain(cfg_chain), .cfg_tag_fwd(cfg_tag_fwd),
      .cfg_irq_en(cfg_irq_en), .start_set(start_set), .init_data_addr(init_data_addr),
      .init_count(init_count), .init_tag_addr(init_tag_addr), .init_spad_addr(init_spad_addr),
      .busy(busy), .done_irq(done_irq), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .spad_we(spad_we),
      .spad_addr(spad_addr), .spad_wdata(spad_wdata));

   // memory model: 256 quadwords, two-cycle response
   logic [QW-1:0] mem [0:255];
   logic          p1_v;
   logic [AW-1:0] p1_a;
   always @(posedge clk) begin
      if (!rst_n) begin
         p1_v <= 1'b0; p1_a <= '0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
      end else begin
         p1_v <= mem_rd_req;
         p1_a <= mem_rd_addr;
         mem_rd_valid <= p1_v;
         mem_rd_data  <= mem[p1_a[11:4]];
      end
   end

   // logs
   logic            clr = 1'b0;
   int              n_rd, n_wr, n_done;
   logic [AW-1:0]   rd_log [0:63];
   logic [QW-1:0]   wr_log [0:63];
   logic [SAW-1:0]  wa_log [0:63];
   always @(posedge clk) begin
      if (clr) begin
         n_rd <= 0; n_wr <= 0; n_done <= 0;
      end else begin
         if (mem_rd_req && n_rd < 64) begin rd_log[n_rd] <= mem_rd_addr; n_rd <= n_rd + 1; end
         if (spad_we && n_wr < 64) begin
            wr_log[n_wr] <= spad_wdata; wa_log[n_wr] <= spad_addr; n_wr <= n_wr + 1;
         end
         if (done_irq) n_done <= n_done + 1;
      end
   end

   int n_chk = 0, n_fail = 0;
   logic [AW-1:0] exp_rd [0:63];
   logic [QW-1:0] exp_wr [0:63];
   int n_er, n_ew;

   task automatic chk(input string req, input logic [QW-1:0] act, input logic [QW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [QW-1:0] patt(input int i);
      return {32'(i * 7 + 3), 32'h5A000000 | 32'(i), ~32'(i), 32'(i)};
   endfunction

   function automatic logic [QW-1:0] mk_tag(input int id, input bit irq, input int cnt, input int addr);
      return {64'hABCD_0000_1234_5678, 32'(addr), irq, 3'(id), 12'h000, 16'(cnt)};
   endfunction

   task automatic init_mem();
      for (int i = 0; i < 256; i++) mem[i] = patt(i);
      n_er = 0; n_ew = 0;
   endtask

   task automatic exp_data(input int addr, input int cnt);
      for (int k = 0; k < cnt; k++) begin
         exp_rd[n_er] = 32'(addr + 16 * k); n_er++;
         exp_wr[n_ew] = mem[(addr >> 4) + k]; n_ew++;
      end
   endtask

   task automatic exp_tag(input int taddr, input bit fwd);
      exp_rd[n_er] = 32'(taddr); n_er++;
      if (fwd) begin exp_wr[n_ew] = mem[taddr >> 4]; n_ew++; end
   endtask

   task automatic run(input string req, input bit ch, input bit fwd, input bit ien,
                      input int daddr, input int cnt, input int taddr, input int saddr);
      int  waited;
      bit  seq_ok;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      cfg_chain = ch; cfg_tag_fwd = fwd; cfg_irq_en = ien;
      init_data_addr = 32'(daddr); init_count = 16'(cnt);
      init_tag_addr = 32'(taddr); init_spad_addr = 8'(saddr);
      start_set = 1'b1;
      @(negedge clk); start_set = 1'b0;
      waited = 0;
      while (n_done == 0 && waited < 3000) begin @(negedge clk); waited++; end
      repeat (3) @(negedge clk);
      chk({req, " R9 done count"}, QW'(n_done), QW'(1));
      chk({req, " R9 busy low"}, QW'(busy), QW'(0));
      chk({req, " read count"}, QW'(n_rd), QW'(n_er));
      chk({req, " write count"}, QW'(n_wr), QW'(n_ew));
      seq_ok = 1'b1;
      for (int k = 0; k < n_er && k < n_rd; k++)
         if (rd_log[k] !== exp_rd[k] && seq_ok) begin
            seq_ok = 1'b0; chk({req, " read addr"}, QW'(rd_log[k]), QW'(exp_rd[k]));
         end
      for (int k = 0; k < n_ew && k < n_wr; k++) begin
         if (wr_log[k] !== exp_wr[k] && seq_ok) begin
            seq_ok = 1'b0; chk({req, " write data"}, wr_log[k], exp_wr[k]);
         end
         if (wa_log[k] !== 8'(saddr + k) && seq_ok) begin
            seq_ok = 1'b0; chk({req, " R2 write slot"}, QW'(wa_log[k]), QW'(8'(saddr + k)));
         end
      end
      if (seq_ok) chk({req, " sequence"}, QW'(1), QW'(1));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      clr = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", QW'({busy, done_irq, spad_we, mem_rd_req}), QW'(0));
      rst_n = 1'b1;
      @(negedge clk); clr = 1'b0;

      // R2 normal mode sweep
      for (int c = 1; c <= 5; c++) begin
         init_mem();
         exp_data(32'h100 + 32'h30 * c, c);
         run("R2 normal", 0, 0, 0, 32'h100 + 32'h30 * c, c, 32'h800, c * 3);
      end

      // R4 R5 R6: continue tag then end tag
      init_mem();
      mem[8'h80] = mk_tag(1, 0, 2, 32'h200);
      mem[8'h83] = mk_tag(7, 0, 3, 32'h300);
      exp_tag(32'h800, 0); exp_data(32'h200, 2);
      exp_tag(32'h830, 0); exp_data(32'h300, 3);
      run("R5 chain", 1, 0, 0, 0, 0, 32'h800, 10);

      // R8 forwarding on same chain
      n_er = 0; n_ew = 0;
      exp_tag(32'h800, 1); exp_data(32'h200, 2);
      exp_tag(32'h830, 1); exp_data(32'h300, 3);
      run("R8 fwd", 1, 1, 0, 0, 0, 32'h800, 20);

      // R6 by-reference end tag, live tag planted after it
      init_mem();
      mem[8'h90] = mk_tag(0, 0, 2, 32'h400);
      mem[8'h93] = mk_tag(1, 0, 1, 32'h410);
      exp_tag(32'h900, 0); exp_data(32'h400, 2);
      run("R6 refend", 1, 0, 0, 0, 0, 32'h900, 0);

      // R7 irq flag with enable: stop
      init_mem();
      mem[8'hA0] = mk_tag(2, 1, 1, 32'h500);
      mem[8'hA2] = mk_tag(7, 0, 1, 32'h520);
      exp_tag(32'hA00, 0); exp_data(32'h500, 1);
      run("R7 irq on", 1, 0, 1, 0, 0, 32'hA00, 0);
      // R7 irq flag without enable: continue
      n_er = 0; n_ew = 0;
      exp_tag(32'hA00, 0); exp_data(32'h500, 1);
      exp_tag(32'hA20, 0); exp_data(32'h520, 1);
      run("R7 irq off", 1, 0, 0, 0, 0, 32'hA00, 0);

      // R3 pending count before first tag
      init_mem();
      mem[8'hB0] = mk_tag(7, 0, 1, 32'h640);
      exp_data(32'h600, 2); exp_tag(32'hB00, 0); exp_data(32'h640, 1);
      run("R3 pending", 1, 0, 0, 32'h600, 2, 32'hB00, 5);

      // R10 zero-count end tag, without and with forwarding
      init_mem();
      mem[8'hC0] = mk_tag(7, 0, 0, 32'h000);
      exp_tag(32'hC00, 0);
      run("R10 zero end", 1, 0, 0, 0, 0, 32'hC00, 0);
      n_er = 0; n_ew = 0;
      exp_tag(32'hC00, 1);
      run("R10 zero end fwd", 1, 1, 0, 0, 0, 32'hC00, 40);

      // R5 zero-count continue tag steps by 16 only
      init_mem();
      mem[8'hD0] = mk_tag(3, 0, 0, 32'h000);
      mem[8'hD1] = mk_tag(7, 0, 1, 32'h700);
      exp_tag(32'hD00, 0); exp_tag(32'hD10, 0); exp_data(32'h700, 1);
      run("R5 zero continue", 1, 0, 0, 0, 0, 32'hD00, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule